// File: doc/BRIEF.md
# Periodic Event Timer Comparator

A register-mapped event timer built around a free-running 32-bit main counter, a global run control and a single timer channel. The channel compares the main counter against a comparator register and flags an interrupt on equality. In periodic mode each hit advances the comparator by a stored period, so hits repeat at a fixed interval. In one-shot mode the comparator is left where it is.

The period lives in an accumulator register that has no address of its own. Software reaches it through the comparator address. A self-clearing steering bit in the channel configuration sends the next comparator write to the accumulator. That write consumes the bit, so any further write lands in the comparator. The usual reprogramming sequence runs as follows:
- halt the counter;
- zero the counter;
- set the steering bit;
- write the period;
- write the first match point;
- restart the counter.

The interrupt output is the channel status gated by the global run control.

Top module: `ptmr_top`

## Requirements
- R1: While the run bit (offset 0, bit 0) is 1 the main counter (offset 2) rises by exactly one per clock. While the run bit is 0 the counter holds its value.
- R2: A write to the main counter loads it only while the run bit is 0. A write made while running is ignored and counting continues.
- R3: Channel configuration is at offset 3, with the steering bit at bit 6. When the steering bit is 1, a write to the comparator address (offset 4) loads the period accumulator and clears the steering bit, which then reads back 0. The comparator keeps its value, and a read of offset 4 always returns the comparator.
- R4: A comparator-address write made while the steering bit is 0 loads the comparator. Two consecutive writes after setting the steering bit therefore load the period first and then the comparator.
- R5: A match is a cycle in which the run bit is 1 and the counter equals the comparator. A match sets the status bit (offset 1, bit 0) only when the channel interrupt-enable bit (configuration bit 2) is 1. Writing 1 to status bit 0 clears the status, and writing 0 leaves it unchanged.
- R6: The interrupt output equals the status bit ANDed with the run bit, so it is low whenever the run bit is 0.
- R7: With periodic mode selected (configuration bit 3 = 1), each match replaces the comparator with comparator plus period, modulo 2^32. In one-shot mode a match leaves the comparator unchanged.
- R8: When a match and a status clear fall in the same cycle, the status ends up set. When a periodic reload and a comparator write fall in the same cycle, the written value wins.
- R9: After reset all readable registers and the interrupt are 0. Reads of offsets 5 to 7 return 0.
- R10: The 32-bit force bit (configuration bit 8) is stored and read back as written. Configuration bits 2, 3 and 8 read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Word offset for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Channel interrupt, gated by the run bit |

## Verification
Two pairs of events can collide in one clock edge. A status clear can coincide with a fresh match, and a software comparator write can coincide with a periodic reload. The bench loads the counter and the comparator with the same value while halted, then starts the counter. It issues the clear or the comparator write on the very next cycle, so that it lands on the edge where the match is evaluated. It then halts the counter and reads back the status or the comparator. The status must still be set, and the comparator must hold the written value rather than the reloaded sum.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    // word offsets of the register port
    localparam int unsigned OFS_GEN = 0;
    localparam int unsigned OFS_STS = 1;
    localparam int unsigned OFS_CNT = 2;
    localparam int unsigned OFS_CFG = 3;
    localparam int unsigned OFS_CMP = 4;
    // channel configuration bit positions
    localparam int unsigned CFG_IE   = 2;
    localparam int unsigned CFG_PER  = 3;
    localparam int unsigned CFG_SETV = 6;
    localparam int unsigned CFG_W32  = 8;
endpackage

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.cnt = st_q.cnt + W'(1);
        end else if (ld) begin
            st_d.cnt = ld_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R1: halted and not loaded -> value frozen
    p_hold_halted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld) |=> $stable(cnt));
    // R1/R2: running counts by one even when a load is attempted
    p_step_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == $past(cnt) + W'(1)));
    // R2: halted load takes the written value
    p_load_halted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && ld) |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
    import ptmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic         cfg_wr,
    input  logic         cmp_wr,
    input  logic         sts_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cfg_rd,
    output logic [W-1:0] cmp,
    output logic         sts
);
    typedef struct packed {
        logic         ie;
        logic         per;
        logic         setv;
        logic         w32;
        logic [W-1:0] cmp;
        logic [W-1:0] acc;
        logic         sts;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   hit;

    assign hit = run && (cnt == st_q.cmp);

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.ie   = wdata[CFG_IE];
            st_d.per  = wdata[CFG_PER];
            st_d.setv = wdata[CFG_SETV];
            st_d.w32  = wdata[CFG_W32];
        end
        if (hit && st_q.per) begin
            st_d.cmp = st_q.cmp + st_q.acc;
        end
        if (cmp_wr) begin
            if (st_q.setv) begin
                st_d.acc  = wdata;
                st_d.setv = 1'b0;
            end else begin
                st_d.cmp = wdata;
            end
        end
        if (sts_clr) st_d.sts = 1'b0;
        if (hit && st_q.ie) st_d.sts = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rd           = '0;
        cfg_rd[CFG_IE]   = st_q.ie;
        cfg_rd[CFG_PER]  = st_q.per;
        cfg_rd[CFG_SETV] = st_q.setv;
        cfg_rd[CFG_W32]  = st_q.w32;
    end

    assign cmp = st_q.cmp;
    assign sts = st_q.sts;

    // R3: steering bit is consumed by the comparator-address write
    p_setv_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && cfg_rd[CFG_SETV]) |=> !cfg_rd[CFG_SETV]);
    // R3: a period load never disturbs the comparator
    p_cmp_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && cfg_rd[CFG_SETV] && !(hit && cfg_rd[CFG_PER])) |=> $stable(cmp));
    // R4: steering bit clear -> comparator takes the written value
    p_cmp_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !cfg_rd[CFG_SETV]) |=> (cmp == $past(wdata)));
    // R7: one-shot match leaves the comparator alone
    p_oneshot_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cfg_rd[CFG_PER] && !cmp_wr) |=> $stable(cmp));
    // R5/R8: a qualified match always leaves status set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cfg_rd[CFG_IE]) |=> sts);
    // R5: status only rises after a qualified match
    p_sts_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(hit && cfg_rd[CFG_IE]));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_GEN = ADDR_W'(OFS_GEN);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(OFS_CMP);

    typedef struct packed {
        logic run;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic [DATA_W-1:0]  cnt, cmp, cfg_rd;
    logic               sts;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == A_GEN) st_d.run = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ptmr_counter #(.W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.run),
        .ld     (wr_en && addr == A_CNT),
        .ld_val (wdata),
        .cnt    (cnt)
    );

    ptmr_channel #(.W(DATA_W)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .cnt     (cnt),
        .cfg_wr  (wr_en && addr == A_CFG),
        .cmp_wr  (wr_en && addr == A_CMP),
        .sts_clr (wr_en && addr == A_STS && wdata[0]),
        .wdata   (wdata),
        .cfg_rd  (cfg_rd),
        .cmp     (cmp),
        .sts     (sts)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            A_GEN:   rdata[0] = st_q.run;
            A_STS:   rdata[0] = sts;
            A_CNT:   rdata    = cnt;
            A_CFG:   rdata    = cfg_rd;
            A_CMP:   rdata    = cmp;
            default: rdata    = '0;
        endcase
    end

    assign irq = sts && st_q.run;

    // R6: no interrupt while halted
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> !irq);
    // R6: interrupt follows status while running
    p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && sts) |-> irq);
endmodule

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;
    localparam int unsigned GEN = 0, STS = 1, CNT = 2, CFG = 3, CMP = 4;
    localparam logic [31:0] IE = 32'h4, PER = 32'h8, SETV = 32'h40, W32 = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    ptmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // starts and ends at a falling edge; captured at the rising edge between
    task automatic wr(input int unsigned a, input logic [31:0] d);
        wr_en = 1'b1; addr = a[2:0]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int unsigned a, output logic [31:0] d);
        addr = a[2:0];
        #1 d = rdata;
    endtask

    // run bit high for k+1 counting edges, then halted
    task automatic run_k(input int k);
        wr(GEN, 1);
        repeat (k) @(negedge clk);
        wr(GEN, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state and unmapped offsets
        for (int a = 0; a < 8; a++) begin
            rd(a, v); chk("R9", v, 0);
        end
        chk("R9 irq", {31'b0, irq}, 0);

        // R1 counting and holding
        for (int k = 0; k < 8; k++) begin
            wr(CNT, 100);
            rd(CNT, v); chk("R2 halted load", v, 100);
            repeat (3) @(negedge clk);
            rd(CNT, v); chk("R1 hold", v, 100);
            run_k(k);
            rd(CNT, v); chk("R1 count", v, 100 + k + 1);
        end

        // R2 write while running is ignored
        wr(CNT, 10);
        wr(GEN, 1);
        wr(CNT, 0);
        wr(GEN, 0);
        rd(CNT, v); chk("R2 running write", v, 12);

        // R10 / R3 config readback, steering bit visible before use
        wr(CFG, IE | W32 | SETV);
        rd(CFG, v); chk("R10", v, IE | W32 | SETV);
        wr(CMP, 32'h1234);
        rd(CFG, v); chk("R3 self-clear", v, IE | W32);
        rd(CMP, v); chk("R3 cmp untouched", v, 0);
        wr(CMP, 5);
        rd(CMP, v); chk("R4 second write", v, 5);

        // R5 / R6 / R7 one-shot sweep, match point 5
        for (int k = 0; k < 10; k++) begin
            wr(STS, 1);
            wr(CNT, 0);
            run_k(k);
            rd(STS, v); chk("R5 one-shot status", v, (k >= 5) ? 1 : 0);
            chk("R6 halted irq", {31'b0, irq}, 0);
            rd(CMP, v); chk("R7 one-shot keep", v, 5);
        end
        // status set: irq appears once running
        wr(GEN, 1);
        chk("R6 irq running", {31'b0, irq}, 1);
        wr(GEN, 0);
        wr(STS, 0);
        rd(STS, v); chk("R5 write 0 keeps", v, 1);
        wr(STS, 1);
        rd(STS, v); chk("R5 clear", v, 0);

        // R5 interrupt enable off: no status
        wr(CFG, 0);
        wr(CNT, 0);
        run_k(9);
        rd(STS, v); chk("R5 ie off", v, 0);

        // R7 / R3 / R4 periodic sweep
        for (int p = 2; p <= 4; p++) begin
            for (int k = 0; k < 12; k++) begin
                int m;
                wr(STS, 1);
                wr(CNT, 0);
                wr(CFG, IE | PER | SETV);
                wr(CMP, p);
                wr(CMP, 3);
                run_k(k);
                m = (k >= 3) ? ((k - 3) / p + 1) : 0;
                rd(CMP, v); chk("R7 periodic", v, 3 + m * p);
                rd(STS, v); chk("R5 periodic status", v, (k >= 3) ? 1 : 0);
            end
        end

        // R7 wrap modulo 2^32
        wr(CFG, PER | SETV);
        wr(CMP, 5);
        wr(CMP, 32'hFFFF_FFFE);
        wr(CNT, 32'hFFFF_FFFE);
        run_k(0);
        rd(CMP, v); chk("R7 wrap", v, 3);

        // R8 status clear and match in the same cycle
        wr(CFG, IE);
        wr(CMP, 32'h20);
        wr(CNT, 32'h20);
        wr(GEN, 1);
        wr(STS, 1);
        wr(GEN, 0);
        rd(STS, v); chk("R8 set beats clear", v, 1);
        wr(CMP, 32'h80);
        wr(CNT, 32'h20);
        wr(GEN, 1);
        wr(STS, 1);
        wr(GEN, 0);
        rd(STS, v); chk("R8 plain clear", v, 0);

        // R8 comparator write and periodic reload in the same cycle
        wr(CFG, PER | SETV);
        wr(CMP, 4);
        wr(CMP, 32'h20);
        wr(CNT, 32'h20);
        wr(GEN, 1);
        wr(CMP, 32'h50);
        wr(GEN, 0);
        rd(CMP, v); chk("R8 write beats reload", v, 32'h50);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule